// File: doc/BRIEF.md
# FSK Carrier PWM Packet Transmitter

This block sends one of two stored 33-bit packets as a frequency-shift keyed square wave on a complementary pair of PWM outputs. A bit timer splits time into bit periods of `BIT_PERIOD` clock cycles. A frame counter counts these periods and wraps after 209 of them. The packet occupies the first 33 periods, sent as three 11-bit words. The remaining 176 periods are silent. The frame then repeats without any outside request.

A carrier generator runs alongside the bit timer. While a data bit is on the line, the carrier period is `MARK_PERIOD` clock cycles for a 1 and `SPACE_PERIOD` clock cycles for a 0. The carrier period is chosen again only when a carrier period ends. Because of this, a bit boundary never cuts a carrier pulse short. The `pkt_sel` input chooses the packet for the coming frame. It is read only at frame boundaries.

Top module: `fsk_pwm_tx`

## Requirements
- R1: A synchronous active-high `rst` holds `pwm_p`, `pwm_n` and `tx_active` low. In the first cycle after `rst` is released, a new frame starts at bit 0.
- R2: `tx_active` is high for exactly the first 33 × `BIT_PERIOD` cycles of each frame and low for the rest of the frame.
- R3: A frame lasts 209 × `BIT_PERIOD` cycles. At its end, transmission restarts from bit 0 with no gap.
- R4: The packet vector P is 33 bits wide. Bit period i of a frame (i = 0 to 32) carries P[32−i]. This places word 0 in P[32:22], word 1 in P[21:11] and word 2 in P[10:0], and sends each word MSB first.
- R5: A carrier period that begins while the bit being sent is 1 lasts `MARK_PERIOD` cycles. One that begins while the bit is 0 lasts `SPACE_PERIOD` cycles. In each carrier period, `pwm_p` is high for the first floor(period/2) cycles and low for the rest.
- R6: While `tx_active` is high, `pwm_n` is the inverse of `pwm_p`.
- R7: While `tx_active` is low, `pwm_p` and `pwm_n` are both low.
- R8: The carrier period length changes only when a carrier period ends. A carrier period that spans a bit boundary keeps its length.
- R9: `pkt_sel` = 1 selects packet `PKT1` and `pkt_sel` = 0 selects packet `PKT0`. The input is sampled only while `rst` is high and in the last cycle of a frame. Changes at any other time have no effect on the frame in progress.
- R10: Every frame begins with a fresh carrier period in its first cycle. That period's length is set by bit 0 of the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_sel | input | 1 | Packet choice for the next frame (1 = PKT1, 0 = PKT0) |
| pwm_p | output | 1 | Carrier PWM output |
| pwm_n | output | 1 | Complementary carrier PWM output |
| tx_active | output | 1 | High while packet data is being sent |

## Verification
The hardest case to reach is a carrier period that is still running when a bit boundary passes, where the next bit has a different value. This is the only situation that shows whether the period switch waits for the carrier to finish. The bit period is therefore set to a length that neither carrier period divides, and the packets contain many mark/space transitions. Random toggling of `pkt_sel` across whole frames tests that the input is ignored mid-frame and used at the frame edge. Occasional random resets land at arbitrary points of the frame and carrier.

// File: rtl/fsk_pwm_tx.sv
module fsk_pwm_tx #(
  parameter int BIT_PERIOD   = 16,
  parameter int MARK_PERIOD  = 4,
  parameter int SPACE_PERIOD = 6,
  parameter int WORD_BITS    = 11,
  parameter int WORDS        = 3,
  parameter int FRAME_BITS   = 209,
  parameter logic [WORD_BITS*WORDS-1:0] PKT0 = 33'h0_F0C3_A55A,
  parameter logic [WORD_BITS*WORDS-1:0] PKT1 = 33'h1_2D4B_7E19
) (
  input  logic clk,
  input  logic rst,
  input  logic pkt_sel,
  output logic pwm_p,
  output logic pwm_n,
  output logic tx_active
);
  localparam int DATA_BITS = WORD_BITS * WORDS;
  localparam int BW   = $clog2(BIT_PERIOD);
  localparam int FW   = $clog2(FRAME_BITS);
  localparam int MAXP = (MARK_PERIOD > SPACE_PERIOD) ? MARK_PERIOD : SPACE_PERIOD;
  localparam int CW   = $clog2(MAXP + 1);

  logic [BW-1:0]        bit_cnt;
  logic [FW-1:0]        frame_idx;
  logic                 sel_q;
  logic [CW-1:0]        car_cnt, per_q, per_eff;
  logic [DATA_BITS-1:0] pkt, pkt_sh;
  logic                 bit_end, frame_end, sending, cur_bit, car_hi;

  assign bit_end   = bit_cnt == BW'(BIT_PERIOD - 1);
  assign frame_end = bit_end && (frame_idx == FW'(FRAME_BITS - 1));
  assign sending   = frame_idx < FW'(DATA_BITS);
  assign pkt       = sel_q ? PKT1 : PKT0;
  assign pkt_sh    = pkt << frame_idx;
  assign cur_bit   = pkt_sh[DATA_BITS-1];
  assign per_eff   = (car_cnt == '0) ? (cur_bit ? CW'(MARK_PERIOD) : CW'(SPACE_PERIOD)) : per_q;
  assign car_hi    = car_cnt < (per_eff >> 1);

  assign tx_active = !rst && sending;
  assign pwm_p     = tx_active && car_hi;
  assign pwm_n     = tx_active && !car_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      frame_idx <= '0;
      sel_q     <= pkt_sel;
    end else begin
      bit_cnt <= bit_end ? '0 : bit_cnt + 1'b1;
      if (frame_end) begin
        frame_idx <= '0;
        sel_q     <= pkt_sel;
      end else if (bit_end) begin
        frame_idx <= frame_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !sending) begin
      car_cnt <= '0;
      per_q   <= per_eff;
    end else begin
      car_cnt <= (car_cnt == per_eff - 1'b1) ? '0 : car_cnt + 1'b1;
      per_q   <= per_eff;
    end
  end
endmodule

// File: rtl/fsk_pwm_tx_chk.sv
module fsk_pwm_tx_chk #(
  parameter int BW = 4,
  parameter int FW = 8,
  parameter int CW = 3,
  parameter int DATA_BITS = 33
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_active,
  input logic          frame_end,
  input logic          sel_q,
  input logic [BW-1:0] bit_cnt,
  input logic [FW-1:0] frame_idx,
  input logic [CW-1:0] car_cnt,
  input logic [CW-1:0] per_eff
);
  // R3
  frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_active) |-> (frame_idx == '0 && bit_cnt == '0));

  // R2
  data_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_active) |-> (frame_idx == FW'(DATA_BITS) && bit_cnt == '0));

  // R8
  period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_active && car_cnt != '0) |-> (per_eff == $past(per_eff)));

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(frame_end) && !$past(rst)) |-> $stable(sel_q));
endmodule

bind fsk_pwm_tx fsk_pwm_tx_chk #(.BW(BW), .FW(FW), .CW(CW), .DATA_BITS(DATA_BITS)) chk_i (
  .clk(clk), .rst(rst), .tx_active(tx_active), .frame_end(frame_end), .sel_q(sel_q),
  .bit_cnt(bit_cnt), .frame_idx(frame_idx), .car_cnt(car_cnt), .per_eff(per_eff)
);

// File: tb/fsk_pwm_tx_tb.sv
module fsk_pwm_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BP = 13;
  localparam int MP = 4;
  localparam int SP = 6;
  localparam int NBITS = 33;
  localparam int FR = 209 * BP;
  localparam logic [32:0] P0 = 33'h0_F0C3_A55A;
  localparam logic [32:0] P1 = 33'h1_2D4B_7E19;

  logic clk = 1'b0, rst = 1'b1, pkt_sel = 1'b1;
  logic pwm_p, pwm_n, tx_active;

  fsk_pwm_tx #(.BIT_PERIOD(BP), .MARK_PERIOD(MP), .SPACE_PERIOD(SP),
               .PKT0(P0), .PKT1(P1)) dut_i (
    .clk(clk), .rst(rst), .pkt_sel(pkt_sel),
    .pwm_p(pwm_p), .pwm_n(pwm_n), .tx_active(tx_active));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int t = 0, sel_e = 1, car_start = 0, car_len = MP;
  bit done = 0;

  function automatic int bit_at(int sel, int i);
    logic [32:0] p = (sel != 0) ? P1 : P0;
    return int'(p[32 - i]);
  endfunction

  function automatic int len_for(int b);
    return (b != 0) ? MP : SP;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      t = 0;
      sel_e = int'(pkt_sel);
    end else begin
      t++;
      if (t % FR == 0) sel_e = int'(pkt_sel);
    end
    if ((t % FR) < NBITS * BP)
      if ((t % FR) == 0 || (t - car_start) >= car_len) begin
        car_start = t;
        car_len = len_for(bit_at(sel_e, (t % FR) / BP));
      end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0d actual=%b expected=%b", tag, t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic ea, ep;
    if (!done) begin
      ea = !rst && ((t % FR) < NBITS * BP);
      ep = ea && ((t - car_start) < car_len / 2);
      if (rst) begin
        chk(tx_active, 1'b0, "R1 tx_active in reset");
        chk(pwm_p, 1'b0, "R1 pwm_p in reset");
        chk(pwm_n, 1'b0, "R1 pwm_n in reset");
      end else begin
        chk(tx_active, ea, "R2 R3 tx_active window");
        chk(pwm_p, ep, "R4 R5 R8 R9 R10 pwm_p carrier");
        if (ea) chk(pwm_n, !ep, "R6 pwm_n complement");
        else    chk(pwm_n, 1'b0, "R7 pwm_n quiet");
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    repeat (FR + 5) @(posedge clk);
    // R9 directed: toggle select mid-frame, then settle on packet 0
    #2 pkt_sel = 1'b0;
    repeat (40) @(posedge clk);
    #2 pkt_sel = 1'b1;
    repeat (40) @(posedge clk);
    #2 pkt_sel = 1'b0;
    repeat (FR * 2) @(posedge clk);
    // R1 directed: reset mid-transmission with packet 1 selected
    #2 begin rst = 1'b1; pkt_sel = 1'b1; end
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    repeat (FR) @(posedge clk);
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      #2;
      if ($urandom % 40 == 0) pkt_sel = ~pkt_sel;
      rst = ($urandom % 5000 == 0);
    end
    #2 rst = 1'b0;
    repeat (FR) @(posedge clk);
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    done = 1;
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    summary();
    $finish;
  end
endmodule